// File: doc/BRIEF.md
# Incremental encoder input decoder

This block sits in front of a position counter. It takes the two raw count inputs (A and B) and the raw index input of an encoder channel. It turns them into a one-cycle count strobe with a direction bit, and into a qualified index level. The channel is configured through plain register inputs. A two-bit decode selector picks pulse/direction operation or quadrature decoding at one, two or four counts per encoder cycle. This selector may change while the block runs.

Both count inputs pass through a synchronizer and then a digital noise filter. The filter samples on ticks of a divided filter clock. The divisor is loaded from the low byte of a preset value by a load strobe. A filtered edge is accepted only when the new level has been seen on two successive filter ticks. In quadrature decoding, a step in which A and B change together has no valid direction. Such a step produces no count and sets a sticky noise error flag. Only the error-clear command clears that flag.

The index is active at a selectable polarity. In synchronous index mode it is further gated by the filtered A and B phase. Synchronous index mode takes effect only while a quadrature decode is selected.

Top module: `qdec_frontend`

## Requirements
- R1: While reset is held, cnt_en, noise_err and idx_active are 0, cnt_up is 1 and psc_div is 0.
- R2: With cfg_mode = 2'b00 (pulse/direction), each accepted rising edge of A gives one count. Its direction equals the filtered B level (1 = up). A falling edge of A and any change of B give no count.
- R3: With cfg_mode = 2'b01 (x1), only A edges count. A rising edge counts when the step is forward, and a falling edge counts when the step is backward.
- R4: With cfg_mode = 2'b10 (x2), every single-input edge of A counts in the direction of the step. B edges give no count.
- R5: With cfg_mode = 2'b11 (x4), every single-input edge of A or B counts. The forward step order of the state {A,B} is 00, 10, 11, 01, 00. Reverse steps count down.
- R6: In any quadrature mode, a step in which filtered A and B change in the same cycle gives no count and sets noise_err.
- R7: noise_err stays set until err_clear is asserted. If a new illegal step and err_clear coincide, the flag stays set.
- R8: In pulse/direction mode, A and B changing together never sets noise_err.
- R9: psc_load copies psc_value into psc_div. The filter samples once every psc_div+1 clocks and accepts a new level only after it has been sampled on two successive ticks. A pulse that spans fewer than two ticks is dropped.
- R10: With synchronous index off, idx_active is 1 exactly when the synchronized index input equals cfg_idx_pol (1 = active high).
- R11: With cfg_idx_sync = 1 in a quadrature mode, idx_active also requires filtered {A,B} = 2'b00.
- R12: In pulse/direction mode, cfg_idx_sync has no effect on idx_active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_a | input | 1 | Raw count input A |
| in_b | input | 1 | Raw count input B (direction in pulse/direction mode) |
| in_idx | input | 1 | Raw index input |
| cfg_mode | input | 2 | Decode select: 00 pulse/direction, 01 x1, 10 x2, 11 x4 |
| cfg_idx_pol | input | 1 | Index active level |
| cfg_idx_sync | input | 1 | Synchronous index enable |
| psc_value | input | 8 | Low byte of the preset, source of the filter divisor |
| psc_load | input | 1 | Load strobe for the filter divisor |
| err_clear | input | 1 | Clears the noise error flag |
| cnt_en | output | 1 | One-cycle count strobe |
| cnt_up | output | 1 | Direction of the latest count (1 = up) |
| idx_active | output | 1 | Qualified index |
| noise_err | output | 1 | Sticky noise error flag |
| psc_div | output | 8 | Current filter divisor |

## Verification
A table walks the filtered {A,B} state through forward and reverse Gray sequences in every decode mode. The net count after each step separates x1 (only the A edge that matches the direction counts), x2 (both A edges) and x4 (all edges). In pulse/direction mode, A rises with B high and then with B falling at the same moment. This separates direction-from-B counting from quadrature decoding, and shows that no error is raised. A step in which both inputs change separates illegal steps from valid ones, and later rows show that the flag holds and then clears. Pulses that are short and long relative to the filter period are applied at two divisor values to separate dropped glitches from accepted edges. The index is toggled against both polarities, against the A/B phase, and against the decode mode.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
  typedef enum logic [1:0] {
    MODE_PD = 2'b00,
    MODE_X1 = 2'b01,
    MODE_X2 = 2'b10,
    MODE_X4 = 2'b11
  } qdec_mode_e;
endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/qdec_prescaler.sv
module qdec_prescaler #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] load_val,
  input  logic             load,
  output logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] phase;

  assign tick = (phase == div);

  always_ff @(posedge clk) begin
    if (rst) begin
      div   <= '0;
      phase <= '0;
    end else if (load) begin
      div   <= load_val;
      phase <= '0;
    end else begin
      phase <= tick ? '0 : phase + 1'b1;
    end
  end
endmodule

// File: rtl/qdec_filter.sv
module qdec_filter #(
  parameter int SYNC_STAGES  = 2,
  parameter int STABLE_TICKS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic raw,
  output logic level
);
  localparam int CW = $clog2(STABLE_TICKS + 1);

  logic          s;
  logic [CW-1:0] seen;

  qdec_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw),
    .q   (s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      level <= 1'b0;
      seen  <= '0;
    end else if (tick) begin
      if (s == level) begin
        seen <= '0;
      end else if (seen == CW'(STABLE_TICKS - 1)) begin
        level <= s;
        seen  <= '0;
      end else begin
        seen <= seen + 1'b1;
      end
    end
  end
endmodule

// File: rtl/qdec_decode.sv
module qdec_decode
  import qdec_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  qdec_mode_e mode,
  input  logic       fa,
  input  logic       fb,
  input  logic       err_clear,
  output logic       cnt_en,
  output logic       cnt_up,
  output logic       noise_err
);
  logic pa, pb;
  logic da, db, fwd;
  logic step, sdir, illegal;

  assign da  = fa ^ pa;
  assign db  = fb ^ pb;
  assign fwd = fa ^ pb;

  always_comb begin
    step    = 1'b0;
    sdir    = fwd;
    illegal = 1'b0;
    case (mode)
      MODE_PD: begin
        step = fa & ~pa;
        sdir = fb;
      end
      MODE_X1: begin
        step    = da & ~db & (fwd ? fa : ~fa);
        illegal = da & db;
      end
      MODE_X2: begin
        step    = da & ~db;
        illegal = da & db;
      end
      default: begin
        step    = da ^ db;
        illegal = da & db;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pa        <= 1'b0;
      pb        <= 1'b0;
      cnt_en    <= 1'b0;
      cnt_up    <= 1'b1;
      noise_err <= 1'b0;
    end else begin
      pa     <= fa;
      pb     <= fb;
      cnt_en <= step;
      if (step) cnt_up <= sdir;
      if (illegal)        noise_err <= 1'b1;
      else if (err_clear) noise_err <= 1'b0;
    end
  end
endmodule

// File: rtl/qdec_index.sv
module qdec_index
  import qdec_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [1:0] IDX_PHASE   = 2'b00
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       raw_idx,
  input  qdec_mode_e mode,
  input  logic       pol,
  input  logic       sync_req,
  input  logic       fa,
  input  logic       fb,
  output logic       active
);
  logic s_idx, hit, sync_eff, aligned;

  qdec_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_idx),
    .q   (s_idx)
  );

  assign hit      = (s_idx == pol);
  assign sync_eff = sync_req && (mode != MODE_PD);
  assign aligned  = ({fa, fb} == IDX_PHASE);

  always_ff @(posedge clk) begin
    if (rst) active <= 1'b0;
    else     active <= hit && (!sync_eff || aligned);
  end
endmodule

// File: rtl/qdec_frontend.sv
module qdec_frontend
  import qdec_pkg::*;
#(
  parameter int         DIV_W        = 8,
  parameter int         SYNC_STAGES  = 2,
  parameter int         STABLE_TICKS = 2,
  parameter logic [1:0] IDX_PHASE    = 2'b00
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_a,
  input  logic             in_b,
  input  logic             in_idx,
  input  logic [1:0]       cfg_mode,
  input  logic             cfg_idx_pol,
  input  logic             cfg_idx_sync,
  input  logic [DIV_W-1:0] psc_value,
  input  logic             psc_load,
  input  logic             err_clear,
  output logic             cnt_en,
  output logic             cnt_up,
  output logic             idx_active,
  output logic             noise_err,
  output logic [DIV_W-1:0] psc_div
);
  localparam int NIN = 2;

  qdec_mode_e     mode;
  logic           ftick;
  logic [NIN-1:0] raw_in;
  logic [NIN-1:0] flt_in;
  logic           flt_a, flt_b;

  assign mode   = qdec_mode_e'(cfg_mode);
  assign raw_in = {in_b, in_a};
  assign flt_a  = flt_in[0];
  assign flt_b  = flt_in[1];

  qdec_prescaler #(.DIV_W(DIV_W)) u_psc (
    .clk      (clk),
    .rst      (rst),
    .load_val (psc_value),
    .load     (psc_load),
    .div      (psc_div),
    .tick     (ftick)
  );

  for (genvar i = 0; i < NIN; i++) begin : g_flt
    qdec_filter #(
      .SYNC_STAGES  (SYNC_STAGES),
      .STABLE_TICKS (STABLE_TICKS)
    ) u_flt (
      .clk   (clk),
      .rst   (rst),
      .tick  (ftick),
      .raw   (raw_in[i]),
      .level (flt_in[i])
    );
  end

  qdec_decode u_dec (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode),
    .fa        (flt_a),
    .fb        (flt_b),
    .err_clear (err_clear),
    .cnt_en    (cnt_en),
    .cnt_up    (cnt_up),
    .noise_err (noise_err)
  );

  qdec_index #(
    .SYNC_STAGES (SYNC_STAGES),
    .IDX_PHASE   (IDX_PHASE)
  ) u_idx (
    .clk      (clk),
    .rst      (rst),
    .raw_idx  (in_idx),
    .mode     (mode),
    .pol      (cfg_idx_pol),
    .sync_req (cfg_idx_sync),
    .fa       (flt_a),
    .fb       (flt_b),
    .active   (idx_active)
  );
endmodule

// File: rtl/qdec_checker.sv
module qdec_checker #(
  parameter logic [1:0] IDX_PHASE = 2'b00
) (
  input logic       clk,
  input logic       rst,
  input logic [1:0] cfg_mode,
  input logic       cfg_idx_sync,
  input logic       err_clear,
  input logic       cnt_en,
  input logic       noise_err,
  input logic       idx_active,
  input logic       fa,
  input logic       fb
);
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (!cnt_en && !noise_err && !idx_active));

  p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (noise_err && !err_clear) |=> noise_err);

  p_clear_only_r7: assert property (@(posedge clk) disable iff (rst)
    ($fell(noise_err) && !$past(rst)) |-> $past(err_clear));

  p_pd_no_err_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(noise_err) |-> ($past(cfg_mode) != 2'b00));

  p_single_step_r6: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && $past(cfg_mode) != 2'b00) |->
      (($past(fa) != $past(fa, 2)) != ($past(fb) != $past(fb, 2))));

  p_idx_sync_r11: assert property (@(posedge clk) disable iff (rst)
    idx_active |->
      $past(!cfg_idx_sync || cfg_mode == 2'b00 || {fa, fb} == IDX_PHASE));
endmodule

bind qdec_frontend qdec_checker #(.IDX_PHASE(IDX_PHASE)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cfg_mode     (cfg_mode),
  .cfg_idx_sync (cfg_idx_sync),
  .err_clear    (err_clear),
  .cnt_en       (cnt_en),
  .noise_err    (noise_err),
  .idx_active   (idx_active),
  .fa           (flt_a),
  .fb           (flt_b)
);

// File: tb/sim_qdec_frontend.sv
module sim_qdec_frontend;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_a = 1'b0, in_b = 1'b0, in_idx = 1'b0;
  logic [1:0] cfg_mode = 2'b00;
  logic       cfg_idx_pol = 1'b1, cfg_idx_sync = 1'b0;
  logic [7:0] psc_value = 8'd0;
  logic       psc_load = 1'b0, err_clear = 1'b0;
  logic       cnt_en, cnt_up, idx_active, noise_err;
  logic [7:0] psc_div;

  int total = 0;
  int bad = 0;
  int pos = 0;
  int pulses = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  qdec_frontend u0 (
    .clk (clk), .rst (rst), .in_a (in_a), .in_b (in_b), .in_idx (in_idx),
    .cfg_mode (cfg_mode), .cfg_idx_pol (cfg_idx_pol), .cfg_idx_sync (cfg_idx_sync),
    .psc_value (psc_value), .psc_load (psc_load), .err_clear (err_clear),
    .cnt_en (cnt_en), .cnt_up (cnt_up), .idx_active (idx_active),
    .noise_err (noise_err), .psc_div (psc_div)
  );

  always @(posedge clk) begin
    if (!rst && cnt_en) begin
      pos    <= pos + (cnt_up ? 1 : -1);
      pulses <= pulses + 1;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000 && !done) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // {mode[1:0], a, b, delta[1:0] (00=0, 01=+1, 10=-1), err, clear_first}
  localparam int NV = 25;
  localparam logic [7:0] VEC [NV] = '{
    8'b00_1_1_01_0_0, 8'b00_0_1_00_0_0, 8'b00_1_0_10_0_0, 8'b00_0_0_00_0_0,
    8'b01_1_0_01_0_0, 8'b01_1_1_00_0_0, 8'b01_0_1_00_0_0, 8'b01_0_0_00_0_0,
    8'b01_0_1_00_0_0, 8'b01_1_1_00_0_0, 8'b01_1_0_00_0_0, 8'b01_0_0_10_0_0,
    8'b10_1_0_01_0_0, 8'b10_1_1_00_0_0, 8'b10_0_1_01_0_0, 8'b10_0_0_00_0_0,
    8'b10_0_1_00_0_0, 8'b10_1_1_10_0_0,
    8'b11_1_0_10_0_0, 8'b11_0_0_10_0_0, 8'b11_1_0_01_0_0, 8'b11_1_1_01_0_0,
    8'b11_0_0_00_1_0, 8'b11_0_0_00_1_0, 8'b11_0_0_00_0_1
  };

  task automatic chk(input string req, input int act, input int exp);
    total = total + 1;
    if (act != exp) begin
      bad = bad + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic string mode_req(input logic [1:0] m);
    case (m)
      2'b00:   return "R2 pulse/direction count";
      2'b01:   return "R3 x1 count";
      2'b10:   return "R4 x2 count";
      default: return "R5 x4 count";
    endcase
  endfunction

  initial begin
    int p0, n0;
    idle(4);
    chk("R1 reset cnt_en", int'(cnt_en), 0);
    chk("R1 reset noise_err", int'(noise_err), 0);
    chk("R1 reset idx_active", int'(idx_active), 0);
    chk("R1 reset cnt_up", int'(cnt_up), 1);
    chk("R1 reset psc_div", int'(psc_div), 0);
    rst = 1'b0;
    idle(4);

    for (int i = 0; i < NV; i++) begin
      logic [7:0] v;
      int exp_d;
      v = VEC[i];
      if (v[0]) begin
        err_clear = 1'b1;
        idle(1);
        err_clear = 1'b0;
      end
      p0 = pos;
      cfg_mode = v[7:6];
      in_a = v[5];
      in_b = v[4];
      idle(12);
      exp_d = (v[3:2] == 2'b01) ? 1 : (v[3:2] == 2'b10) ? -1 : 0;
      chk(mode_req(v[7:6]), pos - p0, exp_d);
      if (v[7:6] == 2'b00)
        chk("R8 no error in pulse/direction", int'(noise_err), int'(v[1]));
      else if (i >= 23)
        chk("R7 sticky error and clear", int'(noise_err), int'(v[1]));
      else
        chk("R6 illegal step error", int'(noise_err), int'(v[1]));
    end

    // R9: filter and prescaler, mode x4, state 00
    p0 = pos; n0 = pulses;
    in_a = 1'b1; idle(1); in_a = 1'b0;
    idle(12);
    chk("R9 one-cycle glitch dropped", pulses - n0, 0);
    psc_value = 8'd9; psc_load = 1'b1; idle(1); psc_load = 1'b0;
    idle(1);
    chk("R9 divisor loaded", int'(psc_div), 9);
    n0 = pulses;
    in_a = 1'b1; idle(8); in_a = 1'b0;
    idle(40);
    chk("R9 pulse shorter than two ticks dropped", pulses - n0, 0);
    p0 = pos;
    in_a = 1'b1; idle(40);
    chk("R9 long pulse accepted", pos - p0, 1);
    in_a = 1'b0; idle(40);
    chk("R9 long pulse release", pos - p0, 0);
    psc_value = 8'd0; psc_load = 1'b1; idle(1); psc_load = 1'b0;
    idle(4);

    // R10: polarity, sync off
    cfg_idx_sync = 1'b0;
    cfg_idx_pol = 1'b1; in_idx = 1'b1; idle(6);
    chk("R10 active-high index asserted", int'(idx_active), 1);
    in_idx = 1'b0; idle(6);
    chk("R10 active-high index released", int'(idx_active), 0);
    cfg_idx_pol = 1'b0; idle(6);
    chk("R10 active-low index asserted", int'(idx_active), 1);
    in_idx = 1'b1; idle(6);
    chk("R10 active-low index released", int'(idx_active), 0);

    // R11: synchronous index in x4
    cfg_idx_pol = 1'b1; cfg_idx_sync = 1'b1; idle(6);
    chk("R11 sync index aligned", int'(idx_active), 1);
    in_a = 1'b1; idle(12);
    chk("R11 sync index blocked off phase", int'(idx_active), 0);

    // R12: same inputs in pulse/direction mode
    cfg_mode = 2'b00; idle(4);
    chk("R12 sync ignored in pulse/direction", int'(idx_active), 1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule